// File: doc/BRIEF.md
# DMA Channel Configuration Error Checker

This block sits beside the channel engine of a multi-channel DMA controller. It validates the programmed parameters of the channel currently being serviced. It also decides when each kind of configuration fault is reported. Each fault class is tied to its own point in the channel's life, so no fault is reported early or late:

- Duplicate priorities are reported when the channel is activated.
- A badly aligned next-descriptor address is reported only when the descriptor chain would be followed at major loop completion.
- A link-enable mismatch between the current and beginning iteration counters is reported only when a minor-loop link is serviced.

A small state machine follows the channel. It has two states:

- `ST_IDLE`: no channel is running. The transition *activate-ok* leads to `ST_RUN`. The transition *activate-fault* stays in `ST_IDLE` and reports a priority error.
- `ST_RUN`: a channel is moving data. The transition *major-done* always returns to `ST_IDLE` and reports an alignment fault if there is one. The transition *minor-link-fault* returns to `ST_IDLE` and reports a link error. A clean minor completion stays in `ST_RUN`.

Every reported fault does three things. It sets a sticky flag for its class, which software clears by writing one. It emits a one-cycle strobe that starts error handling. It raises an interrupt pulse when the error interrupt is enabled.

A channel that faults is not disabled. Activating it again with the same parameters reports the same fault again.

Top module: `dma_cfg_checker`

## Requirements
- R1: After reset, `err_flags` is 000, `err_start` and `err_irq` are 0, and the state machine is in `ST_IDLE`.
- R2: With `fixed_arb`=1, an activation in `ST_IDLE` is a fault when two channels in the same group of `NCH/NGRP` consecutive channels have equal priorities. On the next clock edge, `err_flags[0]` is set and `err_start` pulses for one cycle.
- R3: With `fixed_arb`=1, an activation is also a fault when two groups have equal group priorities. It is reported exactly as in R2.
- R4: Equal channel priorities in different groups are not a fault. With `fixed_arb`=0, no priority duplicate is a fault. In both cases the activation enters `ST_RUN` without reporting.
- R5: In `ST_RUN`, a major-completion strobe with `sg_en`=1 and `sg_addr[4:0]` not zero sets `err_flags[1]` and pulses `err_start` on the next edge. An aligned address, or `sg_en`=0, reports nothing. A major completion always returns to `ST_IDLE`.
- R6: A misaligned scatter/gather address is never reported at activation or at minor completion.
- R7: In `ST_RUN`, a minor-completion strobe without a major strobe, with `link_en`=1 and `citer_link`≠`biter_link`, sets `err_flags[2]`, pulses `err_start` and returns to `ST_IDLE`. A link mismatch is not reported at major completion.
- R8: Completion strobes in `ST_IDLE` and activation strobes in `ST_RUN` have no effect.
- R9: `err_irq` pulses in the same cycle as `err_start` when `irq_en`=1, and stays 0 when `irq_en`=0.
- R10: Writing a 1 to `flag_clr[k]` clears `err_flags[k]` on the next edge. If a new fault of the same class arrives in the same cycle, the set wins.
- R11: After a fault the checker is back in `ST_IDLE`. A repeated activation with the same fault reports it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_arb | input | 1 | Fixed-priority arbitration selected |
| ch_prio | input | NCH*PRIW | Channel priorities; channel c occupies bits [c*PRIW +: PRIW] |
| grp_prio | input | NGRP*GPRIW | Group priorities; group g occupies bits [g*GPRIW +: GPRIW] |
| sg_en | input | 1 | Scatter/gather enabled at completion |
| sg_addr | input | ADDRW | Next-descriptor address |
| link_en | input | 1 | Minor-loop linking enabled |
| citer_link | input | 1 | Link-enable bit of the current iteration counter |
| biter_link | input | 1 | Link-enable bit of the beginning iteration counter |
| act_stb | input | 1 | Channel activation event |
| minor_done_stb | input | 1 | Minor loop completion event |
| major_done_stb | input | 1 | Major loop completion event |
| irq_en | input | 1 | Error interrupt enable |
| flag_clr | input | 3 | Write-one-to-clear for err_flags |
| err_flags | output | 3 | Sticky flags: [0] priority, [1] alignment, [2] link |
| err_start | output | 1 | One-cycle error-handling start strobe |
| err_irq | output | 1 | One-cycle error interrupt request |

## Verification
The hardest conditions to reach from the ports are the ones where a fault is present but must stay silent because the state or the event is wrong. Examples are a misaligned address during activation or minor completion, a link mismatch at major completion, and a priority duplicate presented while a channel is already running. The stimulus first activates a clean channel and only then corrupts the parameters. This places the state machine in `ST_RUN` with a pending fault, and the ignored strobe and the correct one are both applied there. Group and channel duplicates are placed in groups other than the first, so that the comparator network is exercised beyond its first pair.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chk_state_t;

    localparam int FLAG_PRIO  = 0;
    localparam int FLAG_ALIGN = 1;
    localparam int FLAG_LINK  = 2;
    localparam int NFLAGS     = 3;
endpackage

// File: rtl/cfgchk_prio_net.sv
module cfgchk_prio_net #(
    parameter int NCH   = 16,
    parameter int NGRP  = 4,
    parameter int PRIW  = 4,
    parameter int GPRIW = 2
) (
    input  logic [NCH*PRIW-1:0]   ch_prio,
    input  logic [NGRP*GPRIW-1:0] grp_prio,
    output logic                  dup
);
    localparam int CPG = NCH / NGRP;

    logic [NGRP-1:0] grp_dup;
    logic            gp_dup;

    // Pairwise compare of the channels inside each group
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb begin
            grp_dup[g] = 1'b0;
            for (int i = 0; i < CPG - 1; i++) begin
                for (int j = i + 1; j < CPG; j++) begin
                    if (ch_prio[(g*CPG+i)*PRIW +: PRIW] == ch_prio[(g*CPG+j)*PRIW +: PRIW])
                        grp_dup[g] = 1'b1;
                end
            end
        end
    end

    // Pairwise compare of the group priorities
    always_comb begin
        gp_dup = 1'b0;
        for (int a = 0; a < NGRP - 1; a++) begin
            for (int b = a + 1; b < NGRP; b++) begin
                if (grp_prio[a*GPRIW +: GPRIW] == grp_prio[b*GPRIW +: GPRIW])
                    gp_dup = 1'b1;
            end
        end
    end

    assign dup = gp_dup | (|grp_dup);
endmodule

// File: rtl/cfgchk_flags.sv
module cfgchk_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    // R10: a cleared flag with no new fault reads zero on the next edge
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !set[0]) |=> !flags[0]);
    // R10: a new fault wins over a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set[0] && clr[0]) |=> flags[0]);
endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
    import cfgchk_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int NGRP       = 4,
    parameter int PRIW       = 4,
    parameter int GPRIW      = 2,
    parameter int ADDRW      = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fixed_arb,
    input  logic [NCH*PRIW-1:0]   ch_prio,
    input  logic [NGRP*GPRIW-1:0] grp_prio,
    input  logic                  sg_en,
    input  logic [ADDRW-1:0]      sg_addr,
    input  logic                  link_en,
    input  logic                  citer_link,
    input  logic                  biter_link,
    input  logic                  act_stb,
    input  logic                  minor_done_stb,
    input  logic                  major_done_stb,
    input  logic                  irq_en,
    input  logic [2:0]            flag_clr,
    output logic [2:0]            err_flags,
    output logic                  err_start,
    output logic                  err_irq
);
    chk_state_t        state_q, state_d;
    logic              prio_dup;
    logic              sg_misaligned;
    logic [NFLAGS-1:0] ev;

    cfgchk_prio_net #(
        .NCH(NCH), .NGRP(NGRP), .PRIW(PRIW), .GPRIW(GPRIW)
    ) u_prio (
        .ch_prio (ch_prio),
        .grp_prio(grp_prio),
        .dup     (prio_dup)
    );

    assign sg_misaligned = |sg_addr[ALIGN_BITS-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and fault events
    always_comb begin
        state_d = state_q;
        ev      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (act_stb) begin
                    if (fixed_arb && prio_dup) ev[FLAG_PRIO] = 1'b1;
                    else                       state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (major_done_stb) begin
                    state_d = ST_IDLE;
                    if (sg_en && sg_misaligned) ev[FLAG_ALIGN] = 1'b1;
                end else if (minor_done_stb && link_en && (citer_link != biter_link)) begin
                    ev[FLAG_LINK] = 1'b1;
                    state_d       = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_start <= 1'b0;
            err_irq   <= 1'b0;
        end else begin
            err_start <= |ev;
            err_irq   <= (|ev) & irq_en;
        end
    end

    cfgchk_flags #(.NF(NFLAGS)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ev),
        .clr  (flag_clr),
        .flags(err_flags)
    );

    // R2/R3: a priority fault is only raised by an activation
    a_r2_prio_at_act: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[FLAG_PRIO]) |-> $past(act_stb));
    // R5/R6: an alignment fault is only raised by a major completion
    a_r6_align_at_major: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[FLAG_ALIGN]) |-> $past(major_done_stb));
    // R7: a link fault is only raised by a minor completion
    a_r7_link_at_minor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[FLAG_LINK]) |-> $past(minor_done_stb));
    // R9: the interrupt never fires without the handling strobe
    a_r9_irq_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> err_start);
    // R11: every fault returns the checker to idle
    a_r11_idle_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        err_start |-> state_q == ST_IDLE);
    // R8: a strobe needs an event one cycle earlier
    a_r8_start_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        err_start |-> $past(act_stb || minor_done_stb || major_done_stb));
endmodule

// File: tb/sim_dma_cfg_checker.sv
module sim_dma_cfg_checker;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16, NGRP = 4, PRIW = 4, GPRIW = 2, ADDRW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fixed_arb = 1'b1;
    logic [NCH*PRIW-1:0]   ch_prio;
    logic [NGRP*GPRIW-1:0] grp_prio;
    logic sg_en = 1'b0;
    logic [ADDRW-1:0] sg_addr = '0;
    logic link_en = 1'b0, citer_link = 1'b0, biter_link = 1'b0;
    logic act_stb = 1'b0, minor_done_stb = 1'b0, major_done_stb = 1'b0;
    logic irq_en = 1'b1;
    logic [2:0] flag_clr = '0;
    logic [2:0] err_flags;
    logic err_start, err_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_cfg_checker u0 (
        .clk(clk), .rst_n(rst_n), .fixed_arb(fixed_arb),
        .ch_prio(ch_prio), .grp_prio(grp_prio),
        .sg_en(sg_en), .sg_addr(sg_addr), .link_en(link_en),
        .citer_link(citer_link), .biter_link(biter_link),
        .act_stb(act_stb), .minor_done_stb(minor_done_stb),
        .major_done_stb(major_done_stb), .irq_en(irq_en),
        .flag_clr(flag_clr), .err_flags(err_flags),
        .err_start(err_start), .err_irq(err_irq)
    );

    // Monitor: compares outputs just after each edge against the scoreboard
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({err_start, err_irq, err_flags} !== e) begin
                errors++;
                $display("FAIL %s: start/irq/flags got %b/%b/%b expected %b/%b/%b",
                         t, err_start, err_irq, err_flags, e[4], e[3], e[2:0]);
            end
        end
    end

    // Driver: inputs already set; push the result expected after this edge
    task automatic tick(input string r, input logic es, input logic ei, input logic [2:0] ef);
        exp_q.push_back({es, ei, ef});
        tag_q.push_back(r);
        @(negedge clk);
        act_stb = 1'b0; minor_done_stb = 1'b0; major_done_stb = 1'b0; flag_clr = '0;
    endtask

    task automatic clean_prio();
        for (int c = 0; c < NCH; c++) ch_prio[c*PRIW +: PRIW] = PRIW'(c % (NCH/NGRP));
        for (int g = 0; g < NGRP; g++) grp_prio[g*GPRIW +: GPRIW] = GPRIW'(g);
    endtask

    initial begin
        clean_prio();
        repeat (3) @(negedge clk);
        checks++;
        if ({err_start, err_irq, err_flags} !== 5'b0) begin
            errors++;
            $display("FAIL R1: outputs in reset got %b expected 00000", {err_start, err_irq, err_flags});
        end
        rst_n = 1'b1;
        @(negedge clk);
        tick("R1 idle after reset", 0, 0, 3'b000);

        // R4: cross-group equal channel priorities are legal
        act_stb = 1; tick("R4 clean activation", 0, 0, 3'b000);
        major_done_stb = 1; tick("R5 sg off major", 0, 0, 3'b000);

        // R2: duplicate channel priority inside group 1
        ch_prio[5*PRIW +: PRIW] = ch_prio[4*PRIW +: PRIW];
        act_stb = 1; tick("R2 channel dup", 1, 1, 3'b001);
        tick("R2 strobe one cycle", 0, 0, 3'b001);
        act_stb = 1; tick("R11 repeat fault", 1, 1, 3'b001);
        flag_clr = 3'b001; tick("R10 clear", 0, 0, 3'b000);

        // R4: no check without fixed arbitration
        fixed_arb = 0;
        act_stb = 1; tick("R4 round-robin ignores dup", 0, 0, 3'b000);
        major_done_stb = 1; tick("R4 retire", 0, 0, 3'b000);
        fixed_arb = 1;
        clean_prio();

        // R3: duplicate group priority, R9 with interrupt off
        grp_prio[2*GPRIW +: GPRIW] = grp_prio[1*GPRIW +: GPRIW];
        irq_en = 0;
        act_stb = 1; tick("R3 group dup / R9 irq off", 1, 0, 3'b001);
        irq_en = 1;
        // R10: set wins over clear
        act_stb = 1; flag_clr = 3'b001; tick("R10 set wins", 1, 1, 3'b001);
        flag_clr = 3'b001; tick("R10 clear", 0, 0, 3'b000);
        clean_prio();

        // R5/R6: misaligned descriptor address
        sg_en = 1; sg_addr = 32'h0000_1004;
        act_stb = 1; tick("R6 no align fault at activation", 0, 0, 3'b000);
        minor_done_stb = 1; tick("R6 no align fault at minor", 0, 0, 3'b000);
        major_done_stb = 1; tick("R5 align fault at major", 1, 1, 3'b010);
        flag_clr = 3'b010; tick("R10 clear align", 0, 0, 3'b000);
        sg_addr = 32'h0000_1100;
        act_stb = 1; tick("R5 aligned activation", 0, 0, 3'b000);
        major_done_stb = 1; tick("R5 aligned major", 0, 0, 3'b000);
        sg_en = 0;

        // R7: link mismatch
        link_en = 1; citer_link = 1; biter_link = 0;
        act_stb = 1; tick("R7 no link fault at activation", 0, 0, 3'b000);
        major_done_stb = 1; tick("R7 no link fault at major", 0, 0, 3'b000);
        act_stb = 1; tick("R7 reactivate", 0, 0, 3'b000);
        minor_done_stb = 1; tick("R7 link fault at minor", 1, 1, 3'b100);
        flag_clr = 3'b100; tick("R10 clear link", 0, 0, 3'b000);
        biter_link = 1;
        act_stb = 1; tick("R7 matched activation", 0, 0, 3'b000);
        minor_done_stb = 1; tick("R7 matched minor stays running", 0, 0, 3'b000);

        // R8: activation while running is ignored
        ch_prio[9*PRIW +: PRIW] = ch_prio[10*PRIW +: PRIW];
        act_stb = 1; tick("R8 activation in run ignored", 0, 0, 3'b000);
        clean_prio();
        major_done_stb = 1; tick("R8 retire", 0, 0, 3'b000);

        // R8: completions while idle are ignored
        biter_link = 0;
        minor_done_stb = 1; tick("R8 minor in idle ignored", 0, 0, 3'b000);
        sg_en = 1; sg_addr = 32'h0000_0011;
        major_done_stb = 1; tick("R8 major in idle ignored", 0, 0, 3'b000);
        tick("R8 settled", 0, 0, 3'b000);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule